// File: doc/BRIEF.md
# Ring-Passed Block Load Sequencer

This block decides when one processing element, sitting in a ring of identical elements on a shared sample bus, captures the next block of samples. Only one element loads at a time. The element that holds the turn raises a capture enable on each sample strobe and steps a sample index through the block. After it captures the last sample of the block, it raises a hand-off flag. That flag is wired to the load-enable input of the next element in the ring. The last element's flag returns to the first, so the elements keep taking turns with no further outside help.

The ring is started by an external start strobe. Only the element whose start-select input is tied high listens to it. The strobe is asynchronous to the clock and passes through a two-flop synchroniser. Once the synchronised strobe goes low again, the sample strobe that follows is skipped, and the first sample is taken on the second sample strobe. Because of the synchroniser, a strobe edge that lands close to a clock edge can move the start by one sample period. If the ring is left open, an element that has handed off its turn stays idle until a new token or a new start strobe arrives.

Top module: `ring_load_seq`

## Requirements
- R1: A synchronous active-high reset leaves the element idle: no capture enable on any sample strobe, hand-off flag low, sample index 0.
- R2: With start-select high, after the synchronised start strobe has been high and then goes low, the first sample strobe that follows captures nothing. The second sample strobe captures with index 0.
- R3: With start-select low, the start strobe has no effect, and sample strobes produce no capture.
- R4: While loading, each sample strobe asserts the capture enable in its own cycle. The index starts at 0 and goes up by one per capture, up to BLK_LEN-1.
- R5: The capture with index BLK_LEN-1 sets the hand-off flag in the next cycle. The flag stays high until the next sample strobe and drops in the cycle after that strobe.
- R6: After a block completes, sample strobes cause no capture until a token or a start arrives.
- R7: A token on the load-enable input while the element is idle makes the next sample strobe capture with index 0.
- R8: A token that arrives while a block is being loaded is ignored. The index keeps counting.
- R9: Reset asserted partway through a block stops capture and returns the index to 0.
- R10: While the start strobe is held high, no sample is captured. Capture starts only after the strobe falls, as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_sel | input | 1 | High only in the element that may be started externally |
| ext_start | input | 1 | Asynchronous external start strobe, active high |
| smp_stb | input | 1 | Sample strobe, one clock wide |
| tok_in | input | 1 | Load-enable token from the previous element |
| tok_out | output | 1 | Hand-off flag to the next element |
| cap_en | output | 1 | Capture enable for the local sample buffer |
| cap_idx | output | $clog2(BLK_LEN) | Index of the sample being captured |

## Verification
The assertions assume that sample strobes are single-cycle pulses with at least one idle clock between any two. Under that assumption, a hand-off flag is always seen by the next element before the next strobe arrives. They also assume the external start is either held long enough to pass the synchroniser or is left low. The bench drives every strobe as a one-cycle pulse followed by an idle cycle. It holds the start for at least two clocks and drives all inputs on the falling edge, so there are no setup races at the synchroniser.

// File: rtl/ring_load_seq.sv
module ring_load_seq #(
  parameter int BLK_LEN = 256,
  parameter int IW = $clog2(BLK_LEN)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_sel,
  input  logic          ext_start,
  input  logic          smp_stb,
  input  logic          tok_in,
  output logic          tok_out,
  output logic          cap_en,
  output logic [IW-1:0] cap_idx
);
  localparam logic [IW-1:0] LAST = IW'(BLK_LEN - 1);

  typedef enum logic [1:0] {IDLE, ARM, SKIP, LOAD} st_t;
  st_t st;
  logic [1:0] sync;
  logic start_on;

  assign start_on = start_sel & sync[1];
  assign cap_en   = smp_stb & (st == LOAD);

  always_ff @(posedge clk) begin
    if (rst) sync <= 2'b00;
    else     sync <= {sync[0], ext_start};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= IDLE;
      cap_idx <= '0;
      tok_out <= 1'b0;
    end else begin
      if (smp_stb) tok_out <= 1'b0;
      case (st)
        IDLE: if (start_on) st <= ARM;
              else if (tok_in) st <= LOAD;
        ARM:  if (!start_on) st <= SKIP;
        SKIP: if (smp_stb) st <= LOAD;
        LOAD: if (smp_stb) begin
                if (cap_idx == LAST) begin
                  cap_idx <= '0;
                  tok_out <= 1'b1;
                  st      <= IDLE;
                end else begin
                  cap_idx <= cap_idx + 1'b1;
                end
              end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ring_load_seq_chk.sv
module ring_load_seq_chk #(
  parameter int BLK_LEN = 256,
  parameter int IW = $clog2(BLK_LEN)
) (
  input logic          clk,
  input logic          rst,
  input logic          smp_stb,
  input logic          tok_out,
  input logic          cap_en,
  input logic [IW-1:0] cap_idx
);
  a_r1_reset_clears: assert property (@(posedge clk) rst |=> (!tok_out && cap_idx == '0));
  a_r4_idx_bound: assert property (@(posedge clk) disable iff (rst) cap_idx <= IW'(BLK_LEN - 1));
  a_r4_idx_step: assert property (@(posedge clk) disable iff (rst)
    (cap_en && cap_idx != IW'(BLK_LEN - 1)) |=> cap_idx == $past(cap_idx) + 1'b1);
  a_r5_flag_sets: assert property (@(posedge clk) disable iff (rst)
    (cap_en && cap_idx == IW'(BLK_LEN - 1)) |=> (tok_out && cap_idx == '0));
  a_r5_flag_drops: assert property (@(posedge clk) disable iff (rst)
    (tok_out && smp_stb) |=> !tok_out);
  a_r6_no_cap_with_flag: assert property (@(posedge clk) disable iff (rst) tok_out |-> !cap_en);
  a_r4_cap_needs_stb: assert property (@(posedge clk) disable iff (rst) cap_en |-> smp_stb);
endmodule

bind ring_load_seq ring_load_seq_chk #(.BLK_LEN(BLK_LEN), .IW(IW)) u_chk (
  .clk(clk), .rst(rst), .smp_stb(smp_stb), .tok_out(tok_out),
  .cap_en(cap_en), .cap_idx(cap_idx)
);

// File: tb/sim_ring_load_seq.sv
module sim_ring_load_seq;
  localparam int BL = 4;
  localparam int IW = 2;
  localparam int NV = 18;
  // {ext_start, smp_stb, tok_in, exp_cap, exp_idx[1:0], exp_tok}
  localparam logic [6:0] VEC [NV] = '{
    7'b1000000, 7'b1000000, 7'b0000000, 7'b0000000, 7'b0000000,
    7'b0100000, 7'b0000000, 7'b0101000, 7'b0000000, 7'b0101010,
    7'b0000000, 7'b0101100, 7'b0000000, 7'b0101110, 7'b0000001,
    7'b0100001, 7'b0000000, 7'b0100000
  };

  logic clk = 0, rst = 1, start_sel = 1, ext_start = 0, smp_stb = 0, tok_in = 0;
  logic tok_out, cap_en;
  logic [IW-1:0] cap_idx;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  ring_load_seq #(.BLK_LEN(BL)) u0 (
    .clk(clk), .rst(rst), .start_sel(start_sel), .ext_start(ext_start),
    .smp_stb(smp_stb), .tok_in(tok_in), .tok_out(tok_out),
    .cap_en(cap_en), .cap_idx(cap_idx));

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      smp_stb = 0; tok_in = 0;
    end
  endtask

  task automatic stb_chk(string req, int ecap, int eidx);
    @(negedge clk);
    smp_stb = 1;
    #1;
    chk(req, cap_en, ecap);
    if (ecap != 0) chk(req, cap_idx, eidx);
    @(negedge clk);
    smp_stb = 0;
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst = 1; smp_stb = 0; tok_in = 0; ext_start = 0;
    idle(3);
    rst = 0;
  endtask

  initial begin
    #400000;
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    idle(3);
    // R1: reset state, strobe during reset
    @(negedge clk); smp_stb = 1; #1;
    chk("R1 cap_en", cap_en, 0); chk("R1 tok_out", tok_out, 0); chk("R1 idx", cap_idx, 0);
    @(negedge clk); smp_stb = 0; rst = 0;
    idle(2);

    // R2 R4 R5 R6 table walk
    foreach (VEC[i]) begin
      @(negedge clk);
      ext_start = VEC[i][6]; smp_stb = VEC[i][5]; tok_in = VEC[i][4];
      #1;
      chk($sformatf("R2/R4 cap row%0d", i), cap_en, VEC[i][3]);
      if (VEC[i][3]) chk($sformatf("R4 idx row%0d", i), cap_idx, VEC[i][2:1]);
      chk($sformatf("R5/R6 tok row%0d", i), tok_out, VEC[i][0]);
    end
    idle(1);

    // R7: token while idle
    @(negedge clk); tok_in = 1;
    @(negedge clk); tok_in = 0;
    stb_chk("R7 first after token", 1, 0);
    // R8: token during load ignored
    @(negedge clk); tok_in = 1;
    @(negedge clk); tok_in = 0;
    stb_chk("R8 idx continues", 1, 1);
    stb_chk("R8 idx continues", 1, 2);
    stb_chk("R8 last", 1, 3);
    stb_chk("R6 ignored after block", 0, 0);

    // R9: reset mid-block
    @(negedge clk); tok_in = 1;
    @(negedge clk); tok_in = 0;
    stb_chk("R9 pre", 1, 0);
    do_reset();
    #1; chk("R9 idx", cap_idx, 0);
    stb_chk("R9 no capture", 0, 0);

    // R3: start ignored when not selected
    start_sel = 0;
    @(negedge clk); ext_start = 1;
    idle(4);
    @(negedge clk); ext_start = 0;
    idle(4);
    stb_chk("R3 no capture", 0, 0);
    stb_chk("R3 no capture", 0, 0);
    start_sel = 1;

    // R10: start held across strobes
    @(negedge clk); ext_start = 1;
    idle(3);
    stb_chk("R10 held", 0, 0);
    stb_chk("R10 held", 0, 0);
    @(negedge clk); ext_start = 0;
    idle(4);
    stb_chk("R10 skip", 0, 0);
    stb_chk("R10 first", 1, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule